// File: doc/BRIEF.md
# Full/Low-Speed End-of-Packet Qualifier

This block sits between the transmit engine of a USB controller and the 2-bit line state that the PHY reports back over UTMI. While a full-speed or low-speed packet goes out, it watches for the single-ended-zero (SE0) state that marks the end of the packet. It then emits a one-cycle pulse, so that the transmit side knows the PHY has really finished driving the bus before it starts the next packet.

D+ and D- can reach the controller with a few nanoseconds of skew between them. That skew can make one sample look like SE0 while the PHY is still sending data. A qualification mode, switched on by one bit of a memory-mapped control word, rejects such a lone sample. In that mode the line must show SE0 on two back-to-back clock edges before the end of packet counts. The mode acts only in some cases: in host role it covers both speeds, and in device role it covers only a full-speed port during a link-power-management handshake. In every other case a single SE0 sample is enough.

The raw line state first passes through a two-flop synchronizer. The control word has a single live bit, bit 29. All of its other bits read as zero.

Top module: `eop_glitch_qual`

## Requirements
- R1: While `rst` is high and on the first edge after it, `eop_pulse` is 0, `reg_rdata` reads 0 (qualification off), and the SE0 history is cleared.
- R2: A clock edge with `reg_we` high stores `reg_wdata[29]` as the qualification enable. `reg_rdata[29]` returns it from the next cycle on, and every other bit of `reg_rdata` reads 0.
- R3: Line state encoding on `line_state`: 2'b00 = SE0, 2'b01 = J, 2'b10 = K, 2'b11 = SE1. Without qualification, SE0 applied before clock edge 1 with `tx_active` high gives `eop_pulse` high for exactly the cycle after edge 3. The synchronizer accounts for two of those edges.
- R4: With qualification in force, a single SE0 sample produces no pulse. A run of at least two SE0 samples produces one pulse, visible after edge 4, which is one cycle later than in R3.
- R5: In host role (`role_host`=1) qualification is in force whenever it is enabled, for both `speed_fs`=1 (full speed) and `speed_fs`=0 (low speed).
- R6: In device role (`role_host`=0) qualification is in force only when it is enabled, `speed_fs`=1 and `lpm_active`=1. Otherwise a single SE0 sample suffices.
- R7: No pulse is produced for an SE0 that is evaluated while `tx_active` is low. If `tx_active` falls on or before the edge where the SE0 would qualify, no pulse results.
- R8: J, K and SE1 never count toward an end of packet, and a run of them never produces a pulse.
- R9: An unbroken SE0 run produces at most one pulse. Detection re-arms once the line leaves SE0 or `tx_active` drops, so two separate single-sample SE0s without qualification produce two pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | UTMI clock |
| rst | input | 1 | Synchronous active-high reset |
| line_state | input | 2 | Raw line state from the PHY (asynchronous to the clock) |
| tx_active | input | 1 | A packet is being transmitted |
| role_host | input | 1 | 1 = host role, 0 = device role |
| speed_fs | input | 1 | 1 = full-speed port, 0 = low-speed port |
| lpm_active | input | 1 | Link-power-management handshake in progress |
| reg_we | input | 1 | Write strobe for the control word |
| reg_wdata | input | 32 | Control word write data; bit 29 is the enable |
| reg_rdata | output | 32 | Control word read-back |
| eop_pulse | output | 1 | One-cycle end-of-packet detected |

## Verification
Two events can land on the same clock edge: the edge where an SE0 run would qualify, and the fall of `tx_active`. The bench provokes this with a sweep. It holds SE0 for several samples and lowers `tx_active` at each edge offset in turn, with qualification on and off. The expected result is computed from the qualifying edge (3 without qualification, 4 with it): a pulse appears only when `tx_active` is still high at that edge, and never more than one.

// File: rtl/eopq_pkg.sv
package eopq_pkg;

    typedef enum logic [1:0] {
        LS_SE0 = 2'b00,
        LS_J   = 2'b01,
        LS_K   = 2'b10,
        LS_SE1 = 2'b11
    } linestate_t;

    localparam int unsigned CTRL_W       = 32;
    localparam int unsigned CTRL_EN_BIT  = 29;
    localparam int unsigned SYNC_DEPTH   = 2;
    localparam int unsigned QUAL_SAMPLES = 2;

    typedef struct packed {
        logic tx;
        logic host;
        logic fs;
        logic lpm;
    } port_ctx_t;

    function automatic logic qual_in_force(input logic en, input port_ctx_t c);
        return en && (c.host || (c.fs && c.lpm));
    endfunction

    function automatic logic is_se0(input linestate_t ls);
        return ls == LS_SE0;
    endfunction

endpackage

// File: rtl/eopq_sync.sv
module eopq_sync
    import eopq_pkg::*;
#(
    parameter int unsigned STAGES = SYNC_DEPTH
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] d_in,
    output linestate_t q_out
);
    logic [1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    stg[i] <= LS_J;
                end else if (i == 0) begin
                    stg[i] <= d_in;
                end else begin
                    stg[i] <= stg[(i == 0) ? 0 : i - 1];
                end
            end
        end
    endgenerate

    assign q_out = linestate_t'(stg[STAGES-1]);
endmodule

// File: rtl/eopq_ctrl.sv
module eopq_ctrl
    import eopq_pkg::*;
#(
    parameter int unsigned DATA_W = CTRL_W,
    parameter int unsigned EN_BIT = CTRL_EN_BIT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              qual_en
);
    logic en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q <= 1'b0;
        end else if (we) begin
            en_q <= wdata[EN_BIT];
        end
    end

    always_comb begin
        rdata         = '0;
        rdata[EN_BIT] = en_q;
    end

    assign qual_en = en_q;
endmodule

// File: rtl/eopq_detect.sv
module eopq_detect
    import eopq_pkg::*;
#(
    parameter int unsigned NEED_MAX = QUAL_SAMPLES,
    localparam int unsigned CNT_W   = $clog2(NEED_MAX + 1)
) (
    input  logic       clk,
    input  logic       rst,
    input  linestate_t ls,
    input  logic       tx_active,
    input  logic       qualify,
    output logic       eop
);
    logic [CNT_W-1:0] run_cnt;
    logic [CNT_W-1:0] need_m1;
    logic             se0_tx;
    logic             fire;

    assign se0_tx  = tx_active && is_se0(ls);
    assign need_m1 = qualify ? CNT_W'(NEED_MAX - 1) : '0;
    assign fire    = se0_tx && (run_cnt == need_m1);

    always_ff @(posedge clk) begin
        if (rst) begin
            run_cnt <= '0;
            eop     <= 1'b0;
        end else begin
            eop <= fire;
            if (!se0_tx) begin
                run_cnt <= '0;
            end else if (run_cnt != CNT_W'(NEED_MAX)) begin
                run_cnt <= run_cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/eop_glitch_qual.sv
module eop_glitch_qual
    import eopq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic [1:0]  line_state,
    input  logic        tx_active,
    input  logic        role_host,
    input  logic        speed_fs,
    input  logic        lpm_active,
    input  logic        reg_we,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        eop_pulse
);
    linestate_t ls_sync;
    logic       qual_en;
    logic       filt_apply;
    port_ctx_t  ctx;

    assign ctx = '{tx: tx_active, host: role_host, fs: speed_fs, lpm: lpm_active};
    assign filt_apply = qual_in_force(qual_en, ctx);

    eopq_sync #(.STAGES(SYNC_DEPTH)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .d_in  (line_state),
        .q_out (ls_sync)
    );

    eopq_ctrl #(.DATA_W(CTRL_W), .EN_BIT(CTRL_EN_BIT)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .we      (reg_we),
        .wdata   (reg_wdata),
        .rdata   (reg_rdata),
        .qual_en (qual_en)
    );

    eopq_detect #(.NEED_MAX(QUAL_SAMPLES)) u_det (
        .clk       (clk),
        .rst       (rst),
        .ls        (ls_sync),
        .tx_active (ctx.tx),
        .qualify   (filt_apply),
        .eop       (eop_pulse)
    );
endmodule

// File: rtl/eopq_checker.sv
module eopq_checker (
    input logic        clk,
    input logic        rst,
    input logic        eop_pulse,
    input logic        tx_active,
    input logic        reg_we,
    input logic [31:0] reg_wdata,
    input logic [31:0] reg_rdata,
    input logic [1:0]  ls_sync,
    input logic        filt_apply
);
    // R1: the cycle after reset shows no pulse
    p_rst_quiet_r1: assert property (@(posedge clk) $past(rst) |-> !eop_pulse);

    // R2: a write lands in bit 29 and nothing else reads back
    p_reg_readback_r2: assert property (@(posedge clk) disable iff (rst)
        $past(reg_we) |-> (reg_rdata[29] == $past(reg_wdata[29])) && ((reg_rdata & ~32'h2000_0000) == 32'h0));

    // R4: a qualified pulse needs two SE0 samples in a row
    p_two_samples_r4: assert property (@(posedge clk) disable iff (rst)
        (eop_pulse && $past(filt_apply)) |-> ($past(ls_sync) == 2'b00 && $past(ls_sync, 2) == 2'b00));

    // R7: a pulse only follows a transmitting cycle
    p_tx_only_r7: assert property (@(posedge clk) disable iff (rst)
        eop_pulse |-> $past(tx_active));

    // R8: only SE0 can lead to a pulse
    p_se0_only_r8: assert property (@(posedge clk) disable iff (rst)
        eop_pulse |-> $past(ls_sync) == 2'b00);

    // R9: never two pulses back to back
    p_single_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        eop_pulse |=> !eop_pulse);
endmodule

bind eop_glitch_qual eopq_checker u_eopq_checker (
    .clk        (clk),
    .rst        (rst),
    .eop_pulse  (eop_pulse),
    .tx_active  (tx_active),
    .reg_we     (reg_we),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .ls_sync    (ls_sync),
    .filt_apply (filt_apply)
);

// File: tb/test_eop_glitch_qual.sv
`timescale 1ns/1ps
module test_eop_glitch_qual;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  line_state = 2'b01;
    logic        tx_active = 1'b0;
    logic        role_host = 1'b0;
    logic        speed_fs = 1'b0;
    logic        lpm_active = 1'b0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        eop_pulse;

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    eop_glitch_qual i_eop_glitch_qual (
        .clk(clk), .rst(rst), .line_state(line_state), .tx_active(tx_active),
        .role_host(role_host), .speed_fs(speed_fs), .lpm_active(lpm_active),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eop_pulse(eop_pulse)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1;
        reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        reg_wdata = '0;
    endtask

    task automatic settle();
        @(negedge clk);
        tx_active = 1'b1;
        line_state = 2'b01;
        for (int i = 0; i < 3; i++) @(negedge clk);
    endtask

    // SE0 for L samples from edge 1; tx low from edge drop (0 = never)
    task automatic run_se0(input int L, input bit tx, input int drop,
                           output int npulse, output int first);
        npulse = 0;
        first = 0;
        for (int e = 1; e <= 12; e++) begin
            line_state = (e <= L) ? 2'b00 : 2'b01;
            tx_active = tx && (drop == 0 || e < drop);
            @(posedge clk);
            #1;
            if (eop_pulse) begin
                npulse++;
                if (first == 0) first = e;
            end
            @(negedge clk);
        end
        tx_active = 1'b0;
        line_state = 2'b01;
        for (int i = 0; i < 3; i++) @(negedge clk);
    endtask

    task automatic run_pat(input logic [1:0] p [8], output int npulse);
        npulse = 0;
        for (int e = 1; e <= 12; e++) begin
            line_state = (e <= 8) ? p[e-1] : 2'b01;
            tx_active = 1'b1;
            @(posedge clk);
            #1;
            if (eop_pulse) npulse++;
            @(negedge clk);
        end
        tx_active = 1'b0;
        line_state = 2'b01;
        for (int i = 0; i < 3; i++) @(negedge clk);
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int np, fe, need, expn, expf;
        logic [1:0] pat [8];
        bit ap;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(eop_pulse == 1'b0, "R1 eop in reset", int'(eop_pulse), 0);
        chk(reg_rdata == 32'h0, "R1 rdata in reset", int'(reg_rdata), 0);
        rst = 1'b0;
        @(negedge clk);
        chk(eop_pulse == 1'b0, "R1 eop after reset", int'(eop_pulse), 0);

        // R2: register
        wr(32'hFFFF_FFFF);
        chk(reg_rdata == 32'h2000_0000, "R2 write all ones", int'(reg_rdata), 32'h2000_0000);
        wr(32'hDFFF_FFFF);
        chk(reg_rdata == 32'h0, "R2 bit29 clear", int'(reg_rdata), 0);
        wr(32'h2000_0000);
        chk(reg_rdata == 32'h2000_0000, "R2 bit29 only", int'(reg_rdata), 32'h2000_0000);

        // R3 R4 R5 R6 R7: sweep of config x run length
        for (int en = 0; en < 2; en++)
        for (int h = 0; h < 2; h++)
        for (int f = 0; f < 2; f++)
        for (int l = 0; l < 2; l++)
        for (int t = 0; t < 2; t++)
        for (int L = 1; L <= 3; L++) begin
            wr(en ? 32'h2000_0000 : 32'h0);
            role_host = h[0]; speed_fs = f[0]; lpm_active = l[0];
            settle();
            run_se0(L, t[0], 0, np, fe);
            ap = en[0] && (h[0] || (f[0] && l[0]));
            need = ap ? 2 : 1;
            expn = (t != 0 && L >= need) ? 1 : 0;
            expf = expn ? need + 2 : 0;
            if (h != 0)
                chk(np == expn && fe == expf, "R5 host count/edge", np * 100 + fe, expn * 100 + expf);
            else
                chk(np == expn && fe == expf, "R6 device count/edge", np * 100 + fe, expn * 100 + expf);
            if (t == 0) chk(np == 0, "R7 no tx", np, 0);
            else if (ap) chk(np == expn, "R4 qualified", np, expn);
            else chk(np == expn, "R3 single sample", np, expn);
        end

        // R7: tx falls at each edge while SE0 is held (same-cycle case)
        role_host = 1'b1; speed_fs = 1'b0; lpm_active = 1'b0;
        for (int en = 0; en < 2; en++)
        for (int d = 1; d <= 6; d++) begin
            wr(en ? 32'h2000_0000 : 32'h0);
            settle();
            run_se0(5, 1'b1, d, np, fe);
            need = en ? 2 : 1;
            expn = (d > need + 2) ? 1 : 0;
            chk(np == expn, "R7 tx drop", np * 100 + d, expn * 100 + d);
        end

        // R8: J, K, SE1 never count
        for (int en = 0; en < 2; en++) begin
            wr(en ? 32'h2000_0000 : 32'h0);
            settle();
            pat = '{2'b11, 2'b11, 2'b10, 2'b11, 2'b01, 2'b10, 2'b11, 2'b11};
            run_pat(pat, np);
            chk(np == 0, "R8 no SE0", np, 0);
        end

        // R9: long run once; isolated glitches re-arm without qualification
        for (int en = 0; en < 2; en++) begin
            wr(en ? 32'h2000_0000 : 32'h0);
            settle();
            run_se0(8, 1'b1, 0, np, fe);
            chk(np == 1, "R9 long run one pulse", np, 1);
            settle();
            pat = '{2'b00, 2'b01, 2'b00, 2'b10, 2'b00, 2'b11, 2'b01, 2'b01};
            run_pat(pat, np);
            expn = en ? 0 : 3;
            chk(np == expn, "R9 isolated SE0s", np, expn);
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule